// File: doc/BRIEF.md
# Masked Event Interrupt Mapper

This block collects the interrupt-worthy events of an Ethernet controller into one 32-bit event word. It also holds a 32-bit mask word and drives thirteen separate interrupt lines toward the system interrupt controller. The transmit and receive engines report events with single-cycle set pulses. Software reads both words through a small register port and acknowledges events by writing ones to the event word. A write to the transmit-control location with bit 0 set asks for a graceful stop. Transmission in this controller is immediate, so the stop-complete event is raised at once.

The thirteen defined events live in bits 31 down to 19 of the event word. From bit 31 downward they are: heartbeat, babbling receive, babbling transmit, graceful-stop complete, transmit frame, transmit buffer, receive frame, receive buffer, management-interface done, bus error, late collision, retry limit and underrun. The interrupt lines do not follow that positional order. Each line carries a fixed event, and it is asserted while both that event bit and the matching mask bit are set.

Top module: `evt_irq_mapper`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the event word, the mask word and all thirteen interrupt lines are zero.
- R2: A pulse on `hw_set[k]` sets event bit 19+k at the next clock edge. For example, k=0 is underrun at bit 19, k=8 is transmit frame at bit 27, and k=12 is heartbeat at bit 31.
- R3: Writing address 0 (event word) clears every event bit that is 1 in `reg_wdata` and leaves all other bits unchanged.
- R4: Writing address 1 (mask word) replaces all 32 mask bits with `reg_wdata`.
- R5: Interrupt lines 0 to 12 carry the event bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30, in that order.
- R6: Each interrupt line is registered and equals, one clock later, the AND of its event bit and the same mask bit.
- R7: When a set pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R8: Writing address 2 (transmit control) with bit 0 set sets event bit 28 (graceful-stop complete). With bit 0 clear, the write changes no event bit.
- R9: Event bits 18 to 0 always read as zero, whatever is written.
- R10: `reg_rdata` combinationally returns the event word at address 0 and the mask word at address 1, and returns zero at addresses 2 and 3. A write to address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_set | input | 13 | Single-cycle event set pulses; bit k sets event bit 19+k |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 event, 1 mask, 2 transmit control, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 13 | Interrupt lines in the line order of R5 |

## Verification
The hardest case to reach is a clearing write and a hardware set pulse landing on the same event bit in the same cycle. Reaching it means aligning an engine pulse with a bus write, which real traffic produces only by chance. The bench drives both in one cycle on purpose, then repeats the overlap over long stretches of random pulses and writes. A behavioural model with its own line table is compared against the lines on every clock. The line permutation is exercised by raising each event alone under a full mask and checking that exactly one line responds.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int EVT_W     = 32;
    localparam int NUM_LINES = 13;
    localparam int EVT_LSB   = EVT_W - NUM_LINES;
    localparam int ADDR_W    = 2;
    localparam int GRACE_BIT = 28;

    typedef enum logic [ADDR_W-1:0] {
        SEL_EVENT = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_TXCTL = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [EVT_W-1:0] data;
    } reg_req_t;

    // Bits of the event word that may hold a value.
    function automatic logic [EVT_W-1:0] valid_bits();
        logic [EVT_W-1:0] v;
        v = '0;
        for (int b = EVT_LSB; b < EVT_W; b++) v[b] = 1'b1;
        return v;
    endfunction

    // Fixed interrupt-line to event-bit routing.
    function automatic int line_to_bit(int line);
        case (line)
            0:       return 27;
            1:       return 26;
            2:       return 19;
            3:       return 20;
            4:       return 25;
            5:       return 24;
            6:       return 23;
            7:       return 21;
            8:       return 31;
            9:       return 28;
            10:      return 22;
            11:      return 29;
            default: return 30;
        endcase
    endfunction

endpackage

// File: rtl/evt_store.sv
module evt_store
    import evt_irq_pkg::*;
#(
    parameter int W   = EVT_W,
    parameter int LSB = EVT_LSB
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_word,
    input  logic [W-1:0] clr_word,
    output logic [W-1:0] evt_q
);
    localparam logic [W-1:0] KEEP = valid_bits();

    logic [W-1:0] evt_d;

    always_comb begin
        // set is applied after clear, so a set wins
        evt_d = ((evt_q & ~clr_word) | set_word) & KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_d;
    end

    assert_low_zero_R9: assert property (@(posedge clk) disable iff (rst)
        evt_q[LSB-1:0] == '0);

    for (genvar b = LSB; b < W; b++) begin : g_bitchk
        assert_set_R2: assert property (@(posedge clk) disable iff (rst)
            set_word[b] |=> evt_q[b]);
        assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (clr_word[b] && !set_word[b]) |=> !evt_q[b]);
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            (clr_word[b] && set_word[b]) |=> evt_q[b]);
    end
endmodule

// File: rtl/mask_store.sv
module mask_store
    import evt_irq_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (load) mask_q <= load_val;
    end

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (mask_q == $past(load_val)));
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mask_q));
endmodule

// File: rtl/line_router.sv
module line_router
    import evt_irq_pkg::*;
#(
    parameter int W = EVT_W,
    parameter int N = NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] mask,
    output logic [N-1:0] irq_q
);
    for (genvar i = 0; i < N; i++) begin : g_line
        localparam int B = line_to_bit(i);

        always_ff @(posedge clk) begin
            if (rst) irq_q[i] <= 1'b0;
            else     irq_q[i] <= evt[B] & mask[B];
        end

        assert_masked_off_R6: assert property (@(posedge clk) disable iff (rst)
            !mask[B] |=> !irq_q[i]);
        assert_no_event_R5: assert property (@(posedge clk) disable iff (rst)
            !evt[B] |=> !irq_q[i]);
    end
endmodule

// File: rtl/evt_irq_mapper.sv
module evt_irq_mapper
    import evt_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] hw_set,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [EVT_W-1:0]     reg_wdata,
    output logic [EVT_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] irq_o
);
    reg_req_t         req;
    logic [EVT_W-1:0] set_word;
    logic [EVT_W-1:0] clr_word;
    logic [EVT_W-1:0] evt_q;
    logic [EVT_W-1:0] mask_q;
    logic             grace_req;

    always_comb begin
        req.wr   = reg_wr_en;
        req.sel  = reg_sel_e'(reg_addr);
        req.data = reg_wdata;
    end

    always_comb begin
        grace_req = req.wr && (req.sel == SEL_TXCTL) && req.data[0];
        set_word  = {hw_set, {EVT_LSB{1'b0}}};
        set_word[GRACE_BIT] = set_word[GRACE_BIT] | grace_req;
        clr_word  = (req.wr && req.sel == SEL_EVENT) ? req.data : '0;
    end

    evt_store #(.W(EVT_W), .LSB(EVT_LSB)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .set_word (set_word),
        .clr_word (clr_word),
        .evt_q    (evt_q)
    );

    mask_store #(.W(EVT_W)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .load     (req.wr && req.sel == SEL_MASK),
        .load_val (req.data),
        .mask_q   (mask_q)
    );

    line_router #(.W(EVT_W), .N(NUM_LINES)) u_route (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_q),
        .mask  (mask_q),
        .irq_q (irq_o)
    );

    always_comb begin
        case (req.sel)
            SEL_EVENT: reg_rdata = evt_q;
            SEL_MASK:  reg_rdata = mask_q;
            default:   reg_rdata = '0;
        endcase
    end

    assert_grace_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd2 && reg_wdata[0]) |=> evt_q[GRACE_BIT]);
    assert_unused_read_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[1]) |-> (reg_rdata == '0));
    assert_reset_lines_R1: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && evt_q == '0 && mask_q == '0));
endmodule

// File: tb/sim_evt_irq_mapper.sv
module sim_evt_irq_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] hw_set = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [31:0] m_evt = '0;
    logic [31:0] m_mask = '0;
    logic [12:0] m_irq = '0;
    int route [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

    always #4 clk = ~clk;

    evt_irq_mapper u0 (
        .clk(clk), .rst(rst), .hw_set(hw_set), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    always @(posedge clk) begin
        logic [31:0] nxt;
        logic [12:0] li;
        if (rst) begin
            m_evt  <= '0;
            m_mask <= '0;
            m_irq  <= '0;
        end else begin
            for (int i = 0; i < 13; i++) li[i] = m_evt[route[i]] & m_mask[route[i]];
            m_irq <= li;
            nxt = m_evt;
            if (reg_wr_en && reg_addr == 2'd0) nxt = nxt & ~reg_wdata;
            nxt = nxt | ({19'd0, hw_set} << 19);
            if (reg_wr_en && reg_addr == 2'd2 && reg_wdata[0]) nxt[28] = 1'b1;
            m_evt <= nxt & 32'hFFF8_0000;
            if (reg_wr_en && reg_addr == 2'd1) m_mask <= reg_wdata;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // lines compared on every clock, away from the edge
    always @(negedge clk) begin
        if (!done) chk({19'd0, irq_o}, {19'd0, m_irq}, "R6 line compare");
    end

    task automatic drive(input logic wr, input logic [1:0] a, input logic [31:0] d,
                         input logic [12:0] s);
        @(negedge clk);
        #1;
        reg_wr_en = wr; reg_addr = a; reg_wdata = d; hw_set = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 32'd0, 13'd0);
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        drive(1'b0, a, 32'd0, 13'd0);
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rd(2'd0, 32'd0, "R1 event after reset");
        rd(2'd1, 32'd0, "R1 mask after reset");
        chk({19'd0, irq_o}, 32'd0, "R1 lines after reset");
        rst = 1'b0;
        rd(2'd0, 32'd0, "R1 event first cycle");

        drive(1'b1, 2'd1, 32'hFFFF_FFFF, 13'd0);
        rd(2'd1, 32'hFFFF_FFFF, "R4 mask full");

        // each event alone: one line, in the R5 order
        for (int k = 0; k < 13; k++) begin
            drive(1'b0, 2'd0, 32'd0, 13'd1 << k);
            rd(2'd0, 32'd1 << (19 + k), "R2 single set");
            idle(1);
            for (int i = 0; i < 13; i++)
                if (route[i] == 19 + k) chk({19'd0, irq_o}, 32'd1 << i, "R5 line routing");
            drive(1'b1, 2'd0, 32'hFFFF_FFFF, 13'd0);
            rd(2'd0, 32'd0, "R3 clear all");
        end

        drive(1'b0, 2'd0, 32'd0, 13'h1FFF);
        drive(1'b1, 2'd0, 32'h0A00_0000, 13'd0);
        rd(2'd0, 32'hF5F8_0000, "R3 partial clear");

        drive(1'b1, 2'd0, 32'h0800_0000, 13'h0100);
        rd(2'd0, 32'hFDF8_0000, "R7 set wins");

        drive(1'b1, 2'd1, 32'h0000_00FF, 13'd0);
        rd(2'd1, 32'h0000_00FF, "R4 mask replace");
        idle(2);
        chk({19'd0, irq_o}, 32'd0, "R6 masked off");

        drive(1'b1, 2'd0, 32'hFFFF_FFFF, 13'd0);
        drive(1'b1, 2'd2, 32'hFFFF_FFFE, 13'd0);
        rd(2'd0, 32'd0, "R8 no stop bit");
        drive(1'b1, 2'd2, 32'h0000_0001, 13'd0);
        rd(2'd0, 32'h1000_0000, "R8 graceful stop");

        drive(1'b1, 2'd3, 32'hFFFF_FFFF, 13'd0);
        rd(2'd0, 32'h1000_0000, "R10 addr3 write ignored event");
        rd(2'd1, 32'h0000_00FF, "R10 addr3 write ignored mask");
        rd(2'd2, 32'd0, "R10 addr2 reads zero");
        rd(2'd3, 32'd0, "R10 addr3 reads zero");
        chk(reg_rdata & 32'h0007_FFFF, 32'd0, "R9 low bits zero");

        for (int n = 0; n < 2000; n++) begin
            drive(($urandom % 3) == 0, 2'($urandom), $urandom, 13'($urandom) & 13'($urandom));
            if ((n % 7) == 0) begin
                #1;
                chk(reg_rdata, (reg_addr == 2'd0) ? m_evt :
                               (reg_addr == 2'd1) ? m_mask : 32'd0, "R10 random readback");
            end
        end
        idle(2);
        rd(2'd0, m_evt, "R9 final event");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule